// File: doc/BRIEF.md
# Quick DMA Trigger and Completion Controller

This block holds the control state for a bank of quick DMA channels. Each channel is bound by a map register to one parameter slot and to one word inside that slot. A transfer does not start from a start bit. Software arms it by writing the chosen word of the chosen slot. The block watches the parameter-slot window of the register bus. A write that lands on a mapped trigger word of an enabled channel marks that channel as having an outstanding request.

Outstanding requests are offered one at a time to a transfer engine through a valid/acknowledge pair. The lowest-numbered channel goes first, and the slot number of the granted channel travels with the request. A trigger that arrives while its channel is still outstanding is recorded as a missed event and is not queued a second time. The engine reports finished transfers through a completion-code input. Each code sets one bit of a 64-bit pending vector, which software reads and clears in two 32-bit halves. The parameter storage and the data mover are not part of this block.

Top module: `qdma_trigger_ctl`

## Requirements
- R1: After reset every map, enable, secondary-event, missed-event and pending bit is zero, and `req_valid` is low.
- R2: Channel n's map register sits at 0x200 + 4n. A write keeps bits 13:5 as the slot number and bits 4:2 as the trigger-word index, and all other bits read back as zero.
- R3: A bus write to 0x4000 + 32·slot + 4·word, with the low two address bits zero, sets the secondary-event bit of every enabled channel whose map holds that slot and word. The request then appears on `req_valid` at the next clock.
- R4: Writing ones to 0x108C sets enable bits, and writing ones to 0x1088 clears them. Zero bits leave their enable unchanged. The enable vector reads at 0x1084.
- R5: A trigger-word write has no effect on a channel that is disabled or whose map register is zero.
- R6: The secondary-event vector reads at 0x1090. Writing ones to 0x1094 clears the matching bits.
- R7: When `req_valid` and `req_ack` are both high at a clock edge, the secondary-event bit of the channel on `req_chan` clears.
- R8: When several secondary-event bits are set, `req_chan` shows the lowest-numbered one, and `req_slot` shows that channel's mapped slot.
- R9: A trigger hitting a channel whose secondary-event bit is set, and not acknowledged in that same cycle, sets its missed-event bit and queues nothing more. The missed vector reads at 0x310, and writing ones to 0x314 clears bits. A trigger in the acknowledge cycle queues a new request with no miss.
- R10: A pulse on `done_valid` with code c sets pending bit c. Codes 0 to 31 read at 0x1068 as bit c. Codes 32 to 63 read at 0x106C as bit c−32.
- R11: Writing ones to 0x1070 or 0x1074 clears the matching pending bits of the low or high half. If a completion sets a bit in the same cycle that a clear names it, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| req_valid | output | 1 | A channel has an outstanding request |
| req_chan | output | 3 | Channel offered to the engine |
| req_slot | output | 9 | Mapped slot of the offered channel |
| req_ack | input | 1 | Engine accepts the offered request |
| done_valid | input | 1 | Completion report strobe |
| done_code | input | 6 | Completion code to mark pending |

## Verification
The assertion on acknowledge clearing assumes no trigger-word write lands in the acknowledge cycle, so it is guarded by `!bus_wr`. The bench performs such a write only in the one directed case that checks the same-cycle rule against its model. The assertions take the bus to carry one write per clock, so a trigger and a write-one-to-clear can never coincide. The stimulus therefore issues every register access as a single-cycle write. Completion codes are driven as full 6-bit values and may coincide with pending clears, a case the bench exercises on purpose.

// File: rtl/qdma_trigger_ctl.sv
module qdma_trigger_ctl #(
  parameter int NCH    = 8,
  parameter int SLOT_W = 9,
  parameter int WORD_W = 3,
  parameter int CODE_W = 6,
  parameter int AW     = 16,
  parameter int DW     = 32
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  output logic                    req_valid,
  output logic [$clog2(NCH)-1:0]  req_chan,
  output logic [SLOT_W-1:0]       req_slot,
  input  logic                    req_ack,
  input  logic                    done_valid,
  input  logic [CODE_W-1:0]       done_code
);
  localparam int CH_W  = $clog2(NCH);
  localparam int MAP_W = SLOT_W + WORD_W;
  localparam int SPAN  = MAP_W + 2;
  localparam int NCODE = 1 << CODE_W;

  localparam logic [AW-1:0] A_MAP      = AW'(16'h0200);
  localparam logic [AW-1:0] A_MISS_RD  = AW'(16'h0310);
  localparam logic [AW-1:0] A_MISS_CLR = AW'(16'h0314);
  localparam logic [AW-1:0] A_PEND_LO  = AW'(16'h1068);
  localparam logic [AW-1:0] A_PEND_HI  = AW'(16'h106C);
  localparam logic [AW-1:0] A_PCLR_LO  = AW'(16'h1070);
  localparam logic [AW-1:0] A_PCLR_HI  = AW'(16'h1074);
  localparam logic [AW-1:0] A_EN_RD    = AW'(16'h1084);
  localparam logic [AW-1:0] A_EN_CLR   = AW'(16'h1088);
  localparam logic [AW-1:0] A_EN_SET   = AW'(16'h108C);
  localparam logic [AW-1:0] A_SEC_RD   = AW'(16'h1090);
  localparam logic [AW-1:0] A_SEC_CLR  = AW'(16'h1094);

  logic [MAP_W-1:0] map_q [NCH];
  logic [NCH-1:0]   en_q, sec_q, miss_q;
  logic [NCODE-1:0] pend_q;

  logic             aligned, slot_wr, map_hit;
  logic [MAP_W-1:0] wr_key;
  logic [CH_W-1:0]  map_idx;
  logic [NCH-1:0]   trig, ack_mask, en_set, en_clr, sec_clr, miss_clr;
  logic [NCODE-1:0] pend_set, pend_clr;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign slot_wr  = bus_wr && aligned && (bus_addr[AW-1:SPAN] == (AW-SPAN)'(1));
  assign wr_key   = bus_addr[SPAN-1:2];
  assign map_hit  = aligned && (bus_addr[AW-1:CH_W+2] == A_MAP[AW-1:CH_W+2]);
  assign map_idx  = bus_addr[CH_W+1:2];

  assign en_set   = (bus_wr && bus_addr == A_EN_SET)   ? bus_wdata[NCH-1:0] : '0;
  assign en_clr   = (bus_wr && bus_addr == A_EN_CLR)   ? bus_wdata[NCH-1:0] : '0;
  assign sec_clr  = (bus_wr && bus_addr == A_SEC_CLR)  ? bus_wdata[NCH-1:0] : '0;
  assign miss_clr = (bus_wr && bus_addr == A_MISS_CLR) ? bus_wdata[NCH-1:0] : '0;
  assign pend_clr = {(bus_wr && bus_addr == A_PCLR_HI) ? bus_wdata : '0,
                     (bus_wr && bus_addr == A_PCLR_LO) ? bus_wdata : '0};
  assign pend_set = done_valid ? (NCODE'(1) << done_code) : '0;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_trig
      assign trig[g] = slot_wr && en_q[g] && (map_q[g] != '0) && (map_q[g] == wr_key);
    end
  endgenerate

  always_comb begin
    req_chan = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (sec_q[i]) req_chan = CH_W'(i);
  end

  assign req_valid = |sec_q;
  assign req_slot  = map_q[req_chan][MAP_W-1:WORD_W];
  assign ack_mask  = (req_valid && req_ack) ? (NCH'(1) << req_chan) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sec_q  <= '0;
      miss_q <= '0;
      pend_q <= '0;
      for (int i = 0; i < NCH; i++) map_q[i] <= '0;
    end else begin
      en_q   <= (en_q | en_set) & ~en_clr;
      sec_q  <= (sec_q & ~ack_mask & ~sec_clr) | trig;
      miss_q <= (miss_q & ~miss_clr) | (trig & sec_q & ~ack_mask);
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      for (int i = 0; i < NCH; i++)
        if (bus_wr && map_hit && map_idx == CH_W'(i))
          map_q[i] <= bus_wdata[SPAN-1:2];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (map_hit) bus_rdata = DW'({map_q[map_idx], 2'b00});
    else begin
      case (bus_addr)
        A_MISS_RD: bus_rdata = DW'(miss_q);
        A_EN_RD:   bus_rdata = DW'(en_q);
        A_SEC_RD:  bus_rdata = DW'(sec_q);
        A_PEND_LO: bus_rdata = pend_q[DW-1:0];
        A_PEND_HI: bus_rdata = pend_q[2*DW-1:DW];
        default:   bus_rdata = '0;
      endcase
    end
  end

  a_r7_ack_clears_secondary: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack && !bus_wr) |=> !sec_q[$past(req_chan)]);

  a_r8_grant_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (sec_q[req_chan] && ((sec_q & ((NCH'(1) << req_chan) - NCH'(1))) == '0)));

  a_r9_miss_needs_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((miss_q & ~$past(miss_q) & ~$past(sec_q)) == '0));

  a_r10_completion_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> pend_q[$past(done_code)]);

  a_r4_enable_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EN_SET) |=>
      ((en_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));
endmodule

// File: tb/sim_qdma_trigger_ctl.sv
module sim_qdma_trigger_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [15:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        req_valid;
  logic [2:0]  req_chan;
  logic [8:0]  req_slot;
  logic        req_ack = 0;
  logic        done_valid = 0;
  logic [5:0]  done_code = 0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdma_trigger_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_chan(req_chan), .req_slot(req_slot), .req_ack(req_ack),
    .done_valid(done_valid), .done_code(done_code));

  // behavioural reference model
  int          m_map [8];
  logic [7:0]  m_en, m_sec, m_miss;
  logic [63:0] m_pend;

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(input logic [15:0] a);
    if (a >= 16'h0200 && a < 16'h0220 && a[1:0] == 2'b00) return 32'(m_map[(a - 16'h0200) / 4] * 4);
    case (a)
      16'h0310: return {24'h0, m_miss};
      16'h1084: return {24'h0, m_en};
      16'h1090: return {24'h0, m_sec};
      16'h1068: return m_pend[31:0];
      16'h106C: return m_pend[63:32];
      default:  return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_map[i] = 0;
      m_en = 0; m_sec = 0; m_miss = 0; m_pend = 0;
    end else begin
      logic [7:0] ackm, hit;
      ackm = 0; hit = 0;
      if (req_ack && m_sec != 0) ackm[lowest(m_sec)] = 1'b1;
      if (bus_wr && bus_addr >= 16'h4000 && bus_addr < 16'h8000 && bus_addr[1:0] == 2'b00)
        for (int c = 0; c < 8; c++)
          if (m_en[c] && m_map[c] != 0 && m_map[c] == int'((bus_addr - 16'h4000) / 4)) hit[c] = 1'b1;
      for (int c = 0; c < 8; c++)
        if (hit[c] && m_sec[c] && !ackm[c]) m_miss[c] = 1'b1;
      m_sec = m_sec & ~ackm;
      if (bus_wr) begin
        if (bus_addr >= 16'h0200 && bus_addr < 16'h0220 && bus_addr[1:0] == 2'b00)
          m_map[(bus_addr - 16'h0200) / 4] = int'((bus_wdata >> 2) & 32'hFFF);
        case (bus_addr)
          16'h108C: m_en   = m_en | bus_wdata[7:0];
          16'h1088: m_en   = m_en & ~bus_wdata[7:0];
          16'h1094: m_sec  = m_sec & ~bus_wdata[7:0];
          16'h0314: m_miss = m_miss & ~bus_wdata[7:0];
          16'h1070: m_pend[31:0]  = m_pend[31:0]  & ~bus_wdata;
          16'h1074: m_pend[63:32] = m_pend[63:32] & ~bus_wdata;
          default: ;
        endcase
      end
      m_sec = m_sec | hit;
      if (done_valid) m_pend[done_code] = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // wait for the next falling edge and compare against the model
  task automatic tick();
    @(negedge clk);
    cycles++;
    chk("R3 req_valid vs model", 32'(req_valid), 32'(m_sec != 0));
    if (m_sec != 0) begin
      chk("R8 req_chan vs model", 32'(req_chan), 32'(lowest(m_sec)));
      chk("R8 req_slot vs model", 32'(req_slot), 32'((m_map[lowest(m_sec)] >> 3) & 'h1FF));
    end
    chk("R2 bus_rdata vs model", bus_rdata, model_read(bus_addr));
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic expect_rd(input string tag, input logic [15:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    while (cycles < 100000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    expect_rd("R1 enable after reset", 16'h1084, 32'h0);
    expect_rd("R1 pending low after reset", 16'h1068, 32'h0);
    chk("R1 req_valid after reset", 32'(req_valid), 32'h0);

    // R2 map writes: ch2 and ch5 -> slot 5 word 7, ch0 -> slot 3 word 1
    wr(16'h0208, 32'hFFFF_00BF);
    wr(16'h0214, 32'h0000_00BC);
    wr(16'h0200, 32'h0000_0064);
    expect_rd("R2 map ch2 readback", 16'h0208, 32'h0000_00BC);
    expect_rd("R2 map ch0 readback", 16'h0200, 32'h0000_0064);

    // R5 disabled channels ignore the trigger word
    wr(16'h40BC, 32'h1);
    expect_rd("R5 no request while disabled", 16'h1090, 32'h0);

    // R4 enable set/clear
    wr(16'h108C, 32'h25);
    expect_rd("R4 enable set", 16'h1084, 32'h25);
    wr(16'h1088, 32'h01);
    wr(16'h108C, 32'h00);
    expect_rd("R4 enable clear, zero bits no effect", 16'h1084, 32'h24);

    // R3 trigger on ch2 and ch5, R8 lowest first
    wr(16'h40BC, 32'h2);
    expect_rd("R3 secondary bits set", 16'h1090, 32'h24);
    chk("R8 lowest channel first", 32'(req_chan), 32'd2);
    chk("R8 slot of granted channel", 32'(req_slot), 32'd5);

    // R9 retrigger while outstanding
    wr(16'h40BC, 32'h3);
    expect_rd("R9 missed bits set", 16'h0310, 32'h24);
    expect_rd("R9 no second queue", 16'h1090, 32'h24);

    // R7 acknowledge
    req_ack = 1; tick(); req_ack = 0;
    expect_rd("R7 ack clears granted bit", 16'h1090, 32'h20);
    chk("R8 next channel offered", 32'(req_chan), 32'd5);

    // R9 missed W1C, R6 secondary W1C
    wr(16'h0314, 32'h04);
    expect_rd("R9 missed clear", 16'h0310, 32'h20);
    wr(16'h1094, 32'h20);
    expect_rd("R6 secondary clear", 16'h1090, 32'h0);
    chk("R6 request drops", 32'(req_valid), 32'h0);

    // R5 detached channel
    wr(16'h108C, 32'h01);
    wr(16'h0200, 32'h0);
    wr(16'h4064, 32'h0);
    wr(16'h4000, 32'h0);
    expect_rd("R5 detached channel ignored", 16'h1090, 32'h0);

    // R9 trigger in the acknowledge cycle
    wr(16'h0314, 32'hFF);
    wr(16'h40BC, 32'h4);
    req_ack = 1;
    wr(16'h40BC, 32'h5);
    req_ack = 0;
    expect_rd("R9 acked channel requeued without miss", 16'h0310, 32'h20);
    expect_rd("R9 secondary after ack-cycle trigger", 16'h1090, 32'h24);

    // R10 completion codes
    done_valid = 1; done_code = 6'd3; tick();
    done_code = 6'd40; tick();
    done_valid = 0;
    expect_rd("R10 low pending", 16'h1068, 32'h0000_0008);
    expect_rd("R10 high pending", 16'h106C, 32'h0000_0100);

    // R11 clears and set-wins collision
    wr(16'h1070, 32'h8);
    expect_rd("R11 low clear", 16'h1068, 32'h0);
    done_valid = 1; done_code = 6'd40;
    wr(16'h1074, 32'h100);
    done_valid = 0;
    expect_rd("R11 set wins over clear", 16'h106C, 32'h0000_0100);
    wr(16'h1074, 32'h100);
    expect_rd("R11 high clear", 16'h106C, 32'h0);

    repeat (2) tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule